// File: doc/BRIEF.md
# SPI Slave Message Port with Message-Aware Flow Control

This block is the slave side of an SPI link that carries framed messages in both directions at once. The master shifts transmit-message bytes in on MOSI. On the same SCK edges the block shifts out on MISO whatever received-message bytes are waiting in its receive byte stream. When nothing is waiting, MISO carries 0x00. Each message starts with a length byte L (1 to 255), and L payload bytes follow it. Every byte of a message is handed to the transmit byte stream, and the length byte is flagged as the start of the message.

An active-low ready output tells the master whether it may start a new message. Ready follows an almost-full hint from the downstream transmit buffer. The flow control is message-aware. If ready goes high while a message is in progress, the rest of that message is still accepted, but a new message is not accepted until ready returns low. A 0x00 byte clocked in between messages is always a pure read: it pulls received data out and is never forwarded. A non-zero byte that would start a message while ready is high is dropped and sets a sticky error flag.

A 7-bit divisor drives a rate timer. The timer produces a square-wave rate clock, which a master-mode port would use as SCK. The timer's tick also sets when slave select is sampled. All SPI pins are oversampled by the system clock.

Top module: `spi_msg_port`

## Requirements
- R1: While reset is asserted, rdy_n is 1, miso is 0, tx_valid is 0 and err_orphan is 0.
- R2: The rate timer ticks once every D system clocks, where D is rate_div, and a rate_div of 0 counts as 1. rate_clk toggles on every tick. The slave-select level is taken into the port only on ticks.
- R3: The SPI transfer uses mode 0, MSB first. MOSI is sampled on rising SCK and MISO changes after falling SCK. Eight MOSI bits, the first one as bit 7, form one byte.
- R4: During each byte, MISO carries the head of the receive stream (rx_data while rx_valid is 1), MSB first. rx_ready pulses for one cycle only after all 8 bits of a real byte have been shifted out. When rx_valid is 0, the byte shifted out is 0x00.
- R5: A message is a non-zero length byte L followed by L payload bytes. All L+1 bytes appear on tx_data with a one-cycle tx_valid. tx_first is 1 only for the length byte. Payload bytes of any value, including 0x00, are forwarded.
- R6: A 0x00 byte received when no message is in progress is not forwarded and does not set the error flag, whatever the level of rdy_n.
- R7: rdy_n equals tx_almost_full delayed by one clock.
- R8: A message whose length byte was accepted is forwarded in full, even if rdy_n goes high partway through it.
- R9: A non-zero byte received with no message in progress while rdy_n is 1 is not forwarded. It sets err_orphan, which then stays 1 until reset.
- R10: When slave select deasserts, the bit counter clears and a partial byte is dropped. Message progress is kept across the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_div | input | 7 | Rate divisor (0 treated as 1) |
| rate_clk | output | 1 | Square wave toggling on each rate tick |
| sck | input | 1 | SPI clock from master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| rdy_n | output | 1 | Active-low permission to start a message |
| tx_almost_full | input | 1 | Downstream transmit buffer nearly full |
| tx_data | output | 8 | Forwarded message byte |
| tx_valid | output | 1 | One-cycle strobe for tx_data |
| tx_first | output | 1 | Marks the length byte of a message |
| rx_data | input | 8 | Head of the received-message byte stream |
| rx_valid | input | 1 | rx_data holds a pending byte |
| rx_ready | output | 1 | Pops the head byte after it was shifted out |
| err_orphan | output | 1 | Sticky flag for a message start refused while not ready |

## Verification
The bench raises rdy_n between the first and second payload bytes of a message. A port that applied ready to every byte would lose the tail of that message. It clocks 0x00 both as a payload byte and between messages. A design that treated every null as a read would truncate the message, and one that treated every null as data would leak reads into the transmit stream. It drops slave select after four bits. A counter that did not clear would leave every later byte misaligned, and one that also cleared the message state would treat the next payload as a new length. It also drains the receive stream until it is empty. A design that popped a byte at load time, rather than after it was fully shifted out, would show up as a wrong head index.

// File: rtl/spi_msg_port.sv
module spi_msg_port #(
  parameter int DIV_W       = 7,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  rate_div,
  output logic              rate_clk,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso,
  output logic              rdy_n,
  input  logic              tx_almost_full,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              tx_first,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              err_orphan
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  // pin synchronisers
  logic [SYNC_STAGES-1:0] sck_s, ss_s, mosi_s;
  logic sck_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s  <= '0;
      ss_s   <= '1;
      mosi_s <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_s  <= {sck_s[SYNC_STAGES-2:0], sck};
      ss_s   <= {ss_s[SYNC_STAGES-2:0], ss_n};
      mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi};
      sck_d  <= sck_s[SYNC_STAGES-1];
    end

  wire sck_q    = sck_s[SYNC_STAGES-1];
  wire ss_q     = ss_s[SYNC_STAGES-1];
  wire mosi_q   = mosi_s[SYNC_STAGES-1];
  wire sck_rise = sck_q & ~sck_d;
  wire sck_fall = ~sck_q & sck_d;

  // rate timer
  logic [DIV_W-1:0] tmr;
  wire  [DIV_W-1:0] div_eff = (rate_div == '0) ? DIV_W'(1) : rate_div;
  wire              tick    = (tmr >= div_eff - DIV_W'(1));
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmr      <= '0;
      rate_clk <= 1'b0;
    end else begin
      tmr <= tick ? '0 : tmr + DIV_W'(1);
      if (tick) rate_clk <= ~rate_clk;
    end

  // slave select, sampled on ticks only
  logic ss_act, ss_act_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ss_act   <= 1'b0;
      ss_act_d <= 1'b0;
    end else begin
      if (tick) ss_act <= ~ss_q;
      ss_act_d <= ss_act;
    end

  // bit engine
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] in_sr, out_sr;
  logic              out_real;

  wire byte_done = ss_act & sck_rise & (bit_cnt == LAST_BIT);
  wire load_out  = (ss_act & ~ss_act_d) | (ss_act & sck_fall & (bit_cnt == '0));
  wire [BYTE_W-1:0] in_byte = {in_sr[BYTE_W-2:0], mosi_q};

  assign miso = out_sr[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt  <= '0;
      in_sr    <= '0;
      out_sr   <= '0;
      out_real <= 1'b0;
      rx_ready <= 1'b0;
    end else begin
      rx_ready <= byte_done & out_real;
      if (!ss_act) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        in_sr   <= in_byte;
        bit_cnt <= byte_done ? '0 : bit_cnt + CNT_W'(1);
      end
      if (load_out) begin
        out_sr   <= rx_valid ? rx_data : '0;
        out_real <= rx_valid;
      end else if (ss_act & sck_fall) begin
        out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
      end
    end

  // message framing and flow control
  logic              in_msg;
  logic [BYTE_W-1:0] remain;

  wire is_null = (in_byte == '0);
  wire accept  = byte_done & (in_msg | (~is_null & ~rdy_n));
  wire orphan  = byte_done & ~in_msg & ~is_null & rdy_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_msg     <= 1'b0;
      remain     <= '0;
      tx_data    <= '0;
      tx_valid   <= 1'b0;
      tx_first   <= 1'b0;
      err_orphan <= 1'b0;
      rdy_n      <= 1'b1;
    end else begin
      rdy_n    <= tx_almost_full;
      tx_valid <= accept;
      tx_first <= accept & ~in_msg;
      if (accept) tx_data <= in_byte;
      if (byte_done) begin
        if (in_msg) begin
          remain <= remain - BYTE_W'(1);
          if (remain == BYTE_W'(1)) in_msg <= 1'b0;
        end else if (accept) begin
          in_msg <= 1'b1;
          remain <= in_byte;
        end
      end
      if (orphan) err_orphan <= 1'b1;
    end

  AST_SS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_act != $past(ss_act)) |-> $past(tick)); // R2
  AST_POP_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_valid); // R4
  AST_FIRST_NOT_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_first) |-> (tx_data != '0)); // R6
  AST_START_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_first) |-> !$past(rdy_n)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_orphan |=> err_orphan); // R9
  AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_n |-> $past(tx_almost_full) || $past(!rst_n)); // R7
endmodule

// File: tb/spi_msg_port_test.sv
`timescale 1ns/1ps
module spi_msg_port_test;
  localparam int HALF = 8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [6:0] rate_div = 7'd3;
  logic       rate_clk, sck = 1'b0, ss_n = 1'b1, mosi = 1'b0, miso;
  logic       rdy_n, tx_almost_full = 1'b0;
  logic [7:0] tx_data, rx_data;
  logic       tx_valid, tx_first, rx_valid, rx_ready, err_orphan;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [7:0] rxq [16];
  int rhead = 0, rtail = 0;
  assign rx_valid = rhead < rtail;
  assign rx_data  = rxq[rhead[3:0]];
  always @(posedge clk) if (rx_ready) rhead <= rhead + 1;

  logic [7:0] cap  [64];
  logic       capf [64];
  int ncap = 0;
  always @(posedge clk) if (tx_valid) begin
    cap[ncap[5:0]]  <= tx_data;
    capf[ncap[5:0]] <= tx_first;
    ncap <= ncap + 1;
  end

  always #2.5 clk = ~clk;

  spi_msg_port uut (
    .clk(clk), .rst_n(rst_n), .rate_div(rate_div), .rate_clk(rate_clk),
    .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso), .rdy_n(rdy_n),
    .tx_almost_full(tx_almost_full), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_first(tx_first), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .err_orphan(err_orphan));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) begin
      mosi = mo[i];
      wclk(HALF);
      mi[i] = miso;
      sck = 1'b1;
      wclk(HALF);
      sck = 1'b0;
    end
    wclk(HALF);
  endtask

  task automatic send(input logic [7:0] mo);
    logic [7:0] d;
    xfer(mo, d);
  endtask

  task automatic sel(input logic on);
    ss_n = ~on;
    wclk(20);
  endtask

  task automatic measure(output int n);
    logic v;
    @(negedge clk); v = rate_clk;
    while (rate_clk == v) @(negedge clk);
    v = rate_clk; n = 0;
    while (rate_clk == v) begin @(negedge clk); n++; end
  endtask

  // {mosi byte, expected miso byte, forwarded}
  localparam logic [16:0] VEC [6] = '{
    {8'h02, 8'hA5, 1'b1},
    {8'h11, 8'h3C, 1'b1},
    {8'h22, 8'h81, 1'b1},
    {8'h00, 8'h00, 1'b0},
    {8'h01, 8'h00, 1'b1},
    {8'h00, 8'h00, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base, n;
    logic [7:0] got;

    wclk(5);
    chk("R1 rdy_n", rdy_n, 1);
    chk("R1 miso", miso, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 err_orphan", err_orphan, 0);
    rst_n = 1'b1;
    wclk(5);
    chk("R7 rdy_n low", rdy_n, 0);

    measure(n); chk("R2 div3", n, 3);
    rate_div = 7'd0; measure(n); measure(n); chk("R2 div0", n, 1);
    rate_div = 7'd127; measure(n); measure(n); chk("R2 div127", n, 127);
    rate_div = 7'd3; measure(n);

    rxq[0] = 8'hA5; rxq[1] = 8'h3C; rxq[2] = 8'h81; rtail = 3;
    sel(1'b1);
    for (int v = 0; v < 6; v++) begin
      base = ncap;
      xfer(VEC[v][16:9], got);
      chk($sformatf("R3 R4 miso vec%0d", v), got, VEC[v][8:1]);
      chk($sformatf("R5 R6 fwd vec%0d", v), ncap - base, VEC[v][0]);
      if (VEC[v][0]) chk($sformatf("R3 R5 data vec%0d", v), cap[base[5:0]], VEC[v][16:9]);
    end
    chk("R4 pops", rhead, 3);
    chk("R5 first len2", capf[0], 1);
    chk("R5 not first", capf[1], 0);
    chk("R5 first len1", capf[3], 1);
    chk("R6 no err", err_orphan, 0);

    base = ncap;
    send(8'h03); send(8'h11);
    tx_almost_full = 1'b1; wclk(3);
    chk("R7 rdy_n high", rdy_n, 1);
    send(8'h22); send(8'h33);
    chk("R8 tail forwarded", ncap - base, 4);
    chk("R8 last byte", cap[(base + 3) % 64], 8'h33);
    chk("R9 err before", err_orphan, 0);
    send(8'h07);
    chk("R9 dropped", ncap - base, 4);
    chk("R9 err set", err_orphan, 1);
    send(8'h00);
    chk("R6 null while busy", ncap - base, 4);
    tx_almost_full = 1'b0; wclk(3);
    send(8'h01); send(8'h5A);
    chk("R9 resume count", ncap - base, 6);
    chk("R9 resume first", capf[(base + 4) % 64], 1);
    chk("R9 sticky", err_orphan, 1);

    base = ncap;
    send(8'h02); send(8'h44);
    for (int i = 0; i < 4; i++) begin
      mosi = 1'b1; wclk(HALF); sck = 1'b1; wclk(HALF); sck = 1'b0;
    end
    sel(1'b0); sel(1'b1);
    send(8'h55);
    chk("R10 aligned count", ncap - base, 3);
    chk("R10 aligned byte", cap[(base + 2) % 64], 8'h55);
    chk("R10 kept in message", capf[(base + 2) % 64], 0);
    send(8'h00);
    chk("R10 message closed", ncap - base, 3);
    sel(1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule